// File: doc/BRIEF.md
# Segment Access Checker

This block vets one memory access against the segment it names, for protected-mode code that is not running in 64-bit mode. The caller presents the segment's index, selector, attribute bits (readable, writable, grows downward), base and limit. It also presents the code segment's default-size bit, an address-size override flag, the access size and kind, and the virtual address. The block forms the effective offset, which is the address minus the base cut to the active address width. It then decides whether the access passes or raises a general-protection fault, and it reports a cause code for any fault.

The decision is registered. A three-state result machine holds the outcome of the previous cycle. The states are ST_IDLE (no result), ST_PASS (access allowed) and ST_FAULT (access refused). Every clock edge takes one of three transitions, from any state:

- T_quiet goes to ST_IDLE when no request is presented.
- T_grant goes to ST_PASS when a request passes every check.
- T_reject goes to ST_FAULT when a request fails any check.

A request can be presented every cycle. Each result follows its request by exactly one cycle.

Top module: `seg_access_checker`

## Requirements
- R1: A selector of zero faults with cause 1. Segment indices 6, 7, 8 and 9 are exempt from this check. The index encoding is: 0 to 5 are the six architectural segments (1 is the code segment), 6 and 7 are two internal scratch segments, 8 is the task segment and 9 is the interrupt table.
- R2: For data-class segments (indices 0 to 6), a write (kind 1) or a store-check (kind 3) to a segment that is not writable faults with cause 2.
- R3: For data-class segments, a read (kind 0) from a segment that is not readable faults with cause 3. An execute access (kind 2) is never refused for readability.
- R4: The address width is 16 bits when the default-size bit and the override flag are equal, and 32 bits otherwise. The offset is (vaddr - base) truncated to that width and zero-extended on `eff_offset`.
- R5: For a segment that does not grow downward, the access faults with cause 5 if either its first-byte offset or its last-byte offset (offset + bytes - 1) is above the limit. An access that ends exactly at the limit passes.
- R6: For a data-class segment with the grows-down bit set, the access faults with cause 6 if either the first-byte offset or the last-byte offset is at or below the limit. On other segments the grows-down bit is ignored.
- R7: If the last-byte offset carries out of the active address width, the access faults with cause 4.
- R8: Only the highest-priority cause is reported. The order is null selector (1), write denied (2), read denied (3), wrap (4), then limit (5 or 6). A passing access reports cause 0, and `fault` is high exactly when the cause is nonzero while `out_valid` is high.
- R9: The result appears one cycle after `in_valid`. `out_valid` is high only in that cycle, and `fault` and `fault_cause` are 0 when `out_valid` is low. Reset clears every output to 0.
- R10: The access size code 0, 1, 2 or 3 selects 1, 2, 4 or 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| seg_idx | input | 4 | Segment index (R1 encoding) |
| selector | input | 16 | Segment selector value |
| attr_readable | input | 1 | Segment readable |
| attr_writable | input | 1 | Segment writable |
| attr_expand_down | input | 1 | Segment grows downward |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 32 | Segment limit |
| cs_default32 | input | 1 | Code segment default-size bit |
| addr_size_ovr | input | 1 | Address-size override flag |
| acc_size | input | 2 | Access size code (R10) |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 store-check |
| vaddr | input | 32 | Virtual address of the first byte |
| out_valid | output | 1 | Result present |
| fault | output | 1 | General-protection fault |
| fault_cause | output | 3 | Cause code (R8) |
| eff_offset | output | 32 | Effective offset of the access |

## Verification
The hardest outcomes to reach are the ones that need several inputs aligned at once. A wrap needs the offset sitting just under the top of the active width, together with a multi-byte size. That must be tried in both 16-bit and 32-bit mode, and the limit must be set to its maximum so that the limit compare cannot mask the wrap. The stimulus table builds each of these cases explicitly. It also covers a base above the address, where the subtraction itself wraps. It places first-byte and last-byte offsets one either side of the limit for both normal and grows-down segments. Finally, it stacks a null selector on top of a rights violation to show which cause wins.

// File: rtl/seg_chk_pkg.sv
`timescale 1ns/1ps
package seg_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FAULT = 2'd2
    } res_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_NULL  = 3'd1,
        CAUSE_WRITE = 3'd2,
        CAUSE_READ  = 3'd3,
        CAUSE_WRAP  = 3'd4,
        CAUSE_OVER  = 3'd5,
        CAUSE_UNDER = 3'd6
    } cause_e;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_EXEC  = 2'd2;
    localparam logic [1:0] KIND_STCHK = 2'd3;

    localparam int LAST_DATA_IDX = 6;
    localparam int FIRST_EXEMPT  = 6;
    localparam int LAST_EXEMPT   = 9;

    // Data-class segments carry rights and direction attributes.
    function automatic logic is_data_class(input logic [3:0] idx);
        return (int'(idx) <= LAST_DATA_IDX);
    endfunction

    // Segments that are not subject to the zero-selector rule.
    function automatic logic is_null_exempt(input logic [3:0] idx);
        return (int'(idx) >= FIRST_EXEMPT) && (int'(idx) <= LAST_EXEMPT);
    endfunction

endpackage

// File: rtl/seg_rights_check.sv
`timescale 1ns/1ps
module seg_rights_check
    import seg_chk_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic [3:0]       seg_idx,
    input  logic [SEL_W-1:0] selector,
    input  logic             attr_readable,
    input  logic             attr_writable,
    input  logic [1:0]       acc_kind,
    output logic             null_fault,
    output logic             wr_fault,
    output logic             rd_fault
);

    logic data_seg;
    logic wants_write;

    always_comb begin
        data_seg    = is_data_class(seg_idx);
        wants_write = (acc_kind == KIND_WRITE) || (acc_kind == KIND_STCHK);
        null_fault  = (selector == '0) && !is_null_exempt(seg_idx);
        wr_fault    = data_seg && wants_write && !attr_writable;
        rd_fault    = data_seg && (acc_kind == KIND_READ) && !attr_readable;
    end

endmodule

// File: rtl/seg_offset_calc.sv
`timescale 1ns/1ps
module seg_offset_calc #(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 16
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic              cs_default32,
    input  logic              addr_size_ovr,
    input  logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] offset,
    output logic [ADDR_W:0]   end_ext,
    output logic              wrap_fault
);

    localparam int EXT_W = ADDR_W + 1;

    logic              short_mode;
    logic [ADDR_W-1:0] diff;
    logic [3:0]        bytes_m1;

    always_comb begin
        short_mode = (cs_default32 == addr_size_ovr);
        diff       = vaddr - seg_base;
        offset     = short_mode ? {{(ADDR_W-SHORT_W){1'b0}}, diff[SHORT_W-1:0]} : diff;
        bytes_m1   = (4'd1 << acc_size) - 4'd1;
        end_ext    = {1'b0, offset} + EXT_W'(bytes_m1);
        wrap_fault = short_mode ? end_ext[SHORT_W] : end_ext[ADDR_W];
    end

endmodule

// File: rtl/seg_limit_cmp.sv
`timescale 1ns/1ps
module seg_limit_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W:0]   end_ext,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              expand_down,
    output logic              over_fault,
    output logic              under_fault
);

    logic [ADDR_W:0] lim_ext;
    logic            first_above;
    logic            last_above;

    always_comb begin
        lim_ext     = {1'b0, seg_limit};
        first_above = (offset > seg_limit);
        last_above  = (end_ext > lim_ext);
        over_fault  = !expand_down && (first_above || last_above);
        under_fault = expand_down && (!first_above || !last_above);
    end

endmodule

// File: rtl/seg_access_checker.sv
`timescale 1ns/1ps
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        seg_idx,
    input  logic [SEL_W-1:0]  selector,
    input  logic              attr_readable,
    input  logic              attr_writable,
    input  logic              attr_expand_down,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              cs_default32,
    input  logic              addr_size_ovr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] vaddr,
    output logic              out_valid,
    output logic              fault,
    output logic [2:0]        fault_cause,
    output logic [ADDR_W-1:0] eff_offset
);

    localparam int SHORT_W = 16;

    logic              null_f, wr_f, rd_f, wrap_f, over_f, under_f;
    logic [ADDR_W-1:0] offset_c;
    logic [ADDR_W:0]   end_c;
    logic              dir_down;
    cause_e            cause_c, cause_q;
    res_state_e        state_q, state_d;
    logic [ADDR_W-1:0] offset_q;

    seg_rights_check #(.SEL_W(SEL_W)) u_rights (
        .seg_idx       (seg_idx),
        .selector      (selector),
        .attr_readable (attr_readable),
        .attr_writable (attr_writable),
        .acc_kind      (acc_kind),
        .null_fault    (null_f),
        .wr_fault      (wr_f),
        .rd_fault      (rd_f)
    );

    seg_offset_calc #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_offset (
        .vaddr         (vaddr),
        .seg_base      (seg_base),
        .cs_default32  (cs_default32),
        .addr_size_ovr (addr_size_ovr),
        .acc_size      (acc_size),
        .offset        (offset_c),
        .end_ext       (end_c),
        .wrap_fault    (wrap_f)
    );

    assign dir_down = attr_expand_down && is_data_class(seg_idx);

    seg_limit_cmp #(.ADDR_W(ADDR_W)) u_limit (
        .offset      (offset_c),
        .end_ext     (end_c),
        .seg_limit   (seg_limit),
        .expand_down (dir_down),
        .over_fault  (over_f),
        .under_fault (under_f)
    );

    // Fixed cause priority: identity, then rights, then range.
    always_comb begin
        if (null_f)       cause_c = CAUSE_NULL;
        else if (wr_f)    cause_c = CAUSE_WRITE;
        else if (rd_f)    cause_c = CAUSE_READ;
        else if (wrap_f)  cause_c = CAUSE_WRAP;
        else if (over_f)  cause_c = CAUSE_OVER;
        else if (under_f) cause_c = CAUSE_UNDER;
        else              cause_c = CAUSE_NONE;
    end

    // Next-state: T_quiet, T_grant, T_reject from every state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAULT: begin
                if (!in_valid)                 state_d = ST_IDLE;
                else if (cause_c == CAUSE_NONE) state_d = ST_PASS;
                else                           state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q  <= CAUSE_NONE;
            offset_q <= '0;
        end else begin
            cause_q <= in_valid ? cause_c : CAUSE_NONE;
            if (in_valid) offset_q <= offset_c;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        fault       = 1'b0;
        fault_cause = 3'd0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PASS:  out_valid = 1'b1;
            ST_FAULT: begin
                out_valid   = 1'b1;
                fault       = 1'b1;
                fault_cause = cause_q;
            end
            default:  ;
        endcase
        eff_offset = offset_q;
    end

    a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !fault && fault_cause == 3'd0));

    a_r1_null_selector: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && selector == '0 && !is_null_exempt(seg_idx))
        |=> (fault && fault_cause == 3'd1));

    a_r4_short_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cs_default32 == addr_size_ovr)
        |=> ((eff_offset >> SHORT_W) == '0));

    a_r8_fault_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (fault == (fault_cause != 3'd0)));

endmodule

// File: tb/seg_access_checker_bench.sv
`timescale 1ns/1ps
module seg_access_checker_bench;

    typedef struct packed {
        logic [3:0]  idx;
        logic [15:0] sel;
        logic        rd;
        logic        wr;
        logic        ed;
        logic [31:0] base;
        logic [31:0] lim;
        logic        d32;
        logic        ovr;
        logic [1:0]  sz;
        logic [1:0]  kind;
        logic [31:0] va;
        logic        xf;
        logic [2:0]  xc;
        logic [31:0] xo;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 16'h0,  1'b1,1'b1,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd0, 32'h100,      1'b1, 3'd1, 32'h100},       // R1 null
        '{4'd8, 16'h0,  1'b0,1'b0,1'b0, 32'h1000,  32'hFFFF,     1'b1,1'b0, 2'd0, 2'd1, 32'h1010,     1'b0, 3'd0, 32'h10},        // R1 exempt
        '{4'd3, 16'h10, 1'b1,1'b0,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd1, 32'h40,       1'b1, 3'd2, 32'h40},        // R2 write
        '{4'd3, 16'h10, 1'b1,1'b0,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd3, 32'h40,       1'b1, 3'd2, 32'h40},        // R2 store-check
        '{4'd1, 16'h8,  1'b0,1'b0,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd0, 32'h40,       1'b1, 3'd3, 32'h40},        // R3 read
        '{4'd1, 16'h8,  1'b0,1'b0,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd2, 32'h40,       1'b0, 3'd0, 32'h40},        // R3 exec
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h10000, 32'hFFFF,     1'b0,1'b0, 2'd1, 2'd0, 32'h31234,    1'b0, 3'd0, 32'h1234},      // R4 16 (0,0)
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h10000, 32'hFFFF,     1'b1,1'b1, 2'd1, 2'd0, 32'h31234,    1'b0, 3'd0, 32'h1234},      // R4 16 (1,1)
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h10000, 32'hFFFF,     1'b0,1'b1, 2'd1, 2'd0, 32'h31234,    1'b1, 3'd5, 32'h21234},     // R4 32-bit
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h0,     32'h0FFF,     1'b1,1'b0, 2'd2, 2'd0, 32'hFFE,      1'b1, 3'd5, 32'hFFE},       // R5 last byte
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h0,     32'h0FFF,     1'b1,1'b0, 2'd2, 2'd0, 32'hFFC,      1'b0, 3'd0, 32'hFFC},       // R5 exact fit
        '{4'd2, 16'h10, 1'b1,1'b1,1'b1, 32'h0,     32'h0FFF,     1'b1,1'b0, 2'd2, 2'd1, 32'h1000,     1'b0, 3'd0, 32'h1000},      // R6 above
        '{4'd2, 16'h10, 1'b1,1'b1,1'b1, 32'h0,     32'h0FFF,     1'b1,1'b0, 2'd2, 2'd1, 32'hFFF,      1'b1, 3'd6, 32'hFFF},       // R6 at limit
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h0,     32'hFFFFFFFF, 1'b0,1'b0, 2'd2, 2'd0, 32'hFFFE,     1'b1, 3'd4, 32'hFFFE},      // R7 16 wrap
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd3, 2'd0, 32'hFFFFFFFC, 1'b1, 3'd4, 32'hFFFFFFFC},  // R7 32 wrap
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h100,   32'hFFFFFFFF, 1'b1,1'b0, 2'd0, 2'd0, 32'h80,       1'b0, 3'd0, 32'hFFFFFF80},  // R4 base wrap
        '{4'd3, 16'h0,  1'b1,1'b0,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd1, 32'h40,       1'b1, 3'd1, 32'h40},        // R8 null wins
        '{4'd6, 16'h0,  1'b1,1'b0,1'b0, 32'h0,     32'hFFFFFFFF, 1'b1,1'b0, 2'd2, 2'd1, 32'h40,       1'b1, 3'd2, 32'h40},        // R8 exempt rights
        '{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h0,     32'hFF,       1'b1,1'b0, 2'd3, 2'd0, 32'hF8,       1'b0, 3'd0, 32'hF8}         // R10 8 bytes
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:          return "R1";
            2, 3:          return "R2";
            4, 5:          return "R3";
            6, 7, 8, 15:   return "R4";
            9, 10:         return "R5";
            11, 12:        return "R6";
            13, 14:        return "R7";
            16, 17:        return "R8";
            default:       return "R10";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [15:0] selector = '0;
    logic        attr_readable = 1'b0, attr_writable = 1'b0, attr_expand_down = 1'b0;
    logic [31:0] seg_base = '0, seg_limit = '0, vaddr = '0;
    logic        cs_default32 = 1'b0, addr_size_ovr = 1'b0;
    logic [1:0]  acc_size = '0, acc_kind = '0;
    logic        out_valid, fault;
    logic [2:0]  fault_cause;
    logic [31:0] eff_offset;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    seg_access_checker u_seg_access_checker (
        .clk, .rst_n, .in_valid, .seg_idx, .selector, .attr_readable,
        .attr_writable, .attr_expand_down, .seg_base, .seg_limit,
        .cs_default32, .addr_size_ovr, .acc_size, .acc_kind, .vaddr,
        .out_valid, .fault, .fault_cause, .eff_offset
    );

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        seg_idx = v.idx; selector = v.sel;
        attr_readable = v.rd; attr_writable = v.wr; attr_expand_down = v.ed;
        seg_base = v.base; seg_limit = v.lim;
        cs_default32 = v.d32; addr_size_ovr = v.ovr;
        acc_size = v.sz; acc_kind = v.kind; vaddr = v.va;
    endtask

    task automatic check(input string req, input logic xv, input logic xf,
                         input logic [2:0] xc, input logic [31:0] xo, input logic use_off);
        total++;
        if (out_valid !== xv || fault !== xf || fault_cause !== xc ||
            (use_off && eff_offset !== xo)) begin
            fails++;
            $display("FAIL %s: got valid=%0b fault=%0b cause=%0d off=%h, expected valid=%0b fault=%0b cause=%0d off=%h",
                     req, out_valid, fault, fault_cause, eff_offset, xv, xf, xc, xo);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);  // reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);  // idle after reset

        // Back-to-back walk of the table.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(tag_of(i), 1'b1, VECS[i].xf, VECS[i].xc, VECS[i].xo, 1'b1);
        end

        // R9: gap cycle drops valid and clears fault/cause.
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", 1'b0, 1'b0, 3'd0, 32'h0, 1'b0);

        // R9: single request after a gap, then idle again.
        drive(VECS[12]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", 1'b1, 1'b1, 3'd6, 32'hFFF, 1'b1);
        @(negedge clk);
        check("R9", 1'b0, 1'b0, 3'd0, 32'h0, 1'b0);

        // R6: grows-down bit ignored on a non-data segment (index 8).
        drive('{4'd8, 16'h10, 1'b1,1'b1,1'b1, 32'h0, 32'h0FFF, 1'b1,1'b0, 2'd0, 2'd0, 32'h10,
                1'b0, 3'd0, 32'h10});
        @(negedge clk);
        check("R6", 1'b1, 1'b0, 3'd0, 32'h10, 1'b1);

        // R10: 2-byte access ending one past the limit.
        drive('{4'd3, 16'h10, 1'b1,1'b1,1'b0, 32'h0, 32'h0FFF, 1'b1,1'b0, 2'd1, 2'd0, 32'hFFF,
                1'b1, 3'd5, 32'hFFF});
        @(negedge clk);
        check("R10", 1'b1, 1'b1, 3'd5, 32'hFFF, 1'b1);

        // R9: reset in the middle of a fault result clears the outputs.
        drive(VECS[0]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", 1'b0, 1'b0, 3'd0, 32'h0, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: got no completion, expected finish within 5000 cycles");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule